// File: doc/BRIEF.md
# SD card clock generator with strobe control

This block makes the card clock for an SD/MMC host from the base clock. A three-bit divide field selects an exponent n. The card clock then has a period of 2^n base cycles, and n = 0 passes the base clock itself. Software drives the block through a small write port and a read port.

Software writes one-shot strobe bits to a control address. These bits start the clock, stop it, launch a command operation, or begin a soft reset. Software then polls a status word for two things: whether the clock is running, and whether a reset is still in progress.

The clock is gated only while the divided waveform is low, so no shortened pulse ever appears. A new divide value waits for the end of the current divided period. The operation strobe leaves the block as a one-cycle pulse to the command engine. The reset strobe leaves the block as a one-cycle pulse for the whole controller.

Top module: `sd_clk_ctrl`

## Requirements
- R1: Divide field n lives in bits [2:0] of address 2 and reads back from there. The running card clock shows one rising edge every 2^n base cycles; with n = 0 it follows the base clock.
- R2: With n = 7 the card clock runs at the base frequency divided by 128.
- R3: The control register is at address 0. Writing bit 1 starts the card clock and writing bit 0 stops it; if both are written together, stop wins. The bits act once, and address 0 reads back as zero.
- R4: Writing control bit 2 gives exactly one op_start pulse, in the cycle after the write. It may share that write with the start bit.
- R5: Writing control bit 3 gives one soft_rst pulse, and status bit 15 (address 1) then reads 1 for exactly 8 base cycles.
- R6: A soft reset sets the divide field to 0 and stops the card clock. Writes to any address are ignored while status bit 15 reads 1.
- R7: Status bit 8 reads 1 while the card clock is gated on. After a stop it falls within one divided period.
- R8: The card clock starts and stops only while its divided waveform is low, so every high pulse lasts a full half period.
- R9: A new divide value takes effect only at the end of the current divided period.
- R10: After reset the card clock is stopped, the divide field is 0, the status reads 0, and op_start and soft_rst are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 2 divide |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 status, 2 divide |
| rd_data | output | DATA_W | Read data, combinational |
| card_clk | output | 1 | Gated, divided card clock |
| op_start | output | 1 | One-cycle operation launch pulse |
| soft_rst | output | 1 | One-cycle controller reset pulse |

## Verification
The divider is run with n = 0, 3 and 7. Counting card-clock edges over a fixed window tells the three ratios apart, and it also exposes an off-by-one in the exponent. The divide value is changed while the clock runs, and a reference model is compared with the low phase of the card clock on every cycle; together these catch a switch made in the middle of a period. Start and stop are issued at several phases, and a monitor measures the width of every high pulse, so a stop made while the clock is high shows up as a short pulse. A soft reset is sent with writes in the same window, which shows whether those writes are ignored and whether the divide field falls back to 0.

// File: rtl/sd_clk_ctrl.sv
module sd_clk_ctrl #(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              card_clk,
  output logic              op_start,
  output logic              soft_rst
);
  localparam int CNT_W   = (1 << DIV_W) - 1;
  localparam int RCNT_W  = $clog2(RST_CYCLES + 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DIV = 2'd2;
  localparam int B_STOP = 0, B_START = 1, B_OP = 2, B_RST = 3;
  localparam int S_RUN = 8, S_BUSY = 15;

  logic [DIV_W-1:0]  div_q, div_pend, nxt_div;
  logic [CNT_W-1:0]  cnt, nxt_cnt, period_last;
  logic [CNT_W:0]    one_sh;
  logic [RCNT_W-1:0] rst_cnt;
  logic              busy, want_run, run_q, lvl_q, nxt_lvl;
  logic              gate_n, div0_n, boundary;
  logic              wr_ok, wr_ctrl, wr_div;
  logic              unused_wr_hi;

  assign busy    = (rst_cnt != '0);
  assign wr_ok   = wr_en && !busy;
  assign wr_ctrl = wr_ok && (wr_addr == A_CTRL);
  assign wr_div  = wr_ok && (wr_addr == A_DIV);
  assign unused_wr_hi = &{1'b0, wr_data[DATA_W-1:4]};

  assign one_sh      = (CNT_W+1)'(1) << div_q;
  assign period_last = CNT_W'(one_sh - 1'b1);
  assign boundary    = (cnt == period_last);
  assign nxt_cnt     = boundary ? '0 : cnt + 1'b1;
  assign nxt_div     = boundary ? div_pend : div_q;
  assign nxt_lvl     = (nxt_div == '0) ? 1'b0 : nxt_cnt[DIV_W'(nxt_div - 1'b1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt   <= nxt_cnt;
      div_q <= nxt_div;
      lvl_q <= nxt_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt  <= '0;
      div_pend <= '0;
      want_run <= 1'b0;
      op_start <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      op_start <= 1'b0;
      soft_rst <= 1'b0;
      if (busy) rst_cnt <= rst_cnt - 1'b1;
      if (wr_ctrl && wr_data[B_RST]) begin
        rst_cnt  <= RCNT_W'(RST_CYCLES);
        soft_rst <= 1'b1;
        div_pend <= '0;
        want_run <= 1'b0;
      end else if (wr_ctrl) begin
        if (wr_data[B_START]) want_run <= 1'b1;
        if (wr_data[B_STOP])  want_run <= 1'b0;
        op_start <= wr_data[B_OP];
      end
      if (wr_div) div_pend <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                run_q <= 1'b0;
    else if (want_run != run_q && !nxt_lvl)    run_q <= want_run;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_n <= 1'b0;
      div0_n <= 1'b1;
    end else begin
      gate_n <= run_q;
      div0_n <= (div_q == '0);
    end
  end

  assign card_clk = gate_n & (div0_n ? clk : lvl_q);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT: begin
        rd_data[S_BUSY] = busy;
        rd_data[S_RUN]  = run_q;
      end
      A_DIV:   rd_data[DIV_W-1:0] = div_pend;
      default: rd_data = '0;
    endcase
  end
endmodule

module sd_clk_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 3,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_start,
  input logic              soft_rst,
  input logic              busy,
  input logic              run_q,
  input logic              lvl_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [DIV_W-1:0]  div_pend,
  input logic [CNT_W-1:0]  cnt
);
  AST_OP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wr_en && wr_addr == 2'd0 && wr_data[2])); // R4
  AST_RST_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> busy); // R5
  AST_RESET_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (div_pend == '0)); // R6
  AST_GATE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != $past(run_q)) |-> !lvl_q); // R8
  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> (cnt == '0)); // R9
endmodule

bind sd_clk_ctrl sd_clk_ctrl_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .op_start(op_start), .soft_rst(soft_rst), .busy(busy), .run_q(run_q),
  .lvl_q(lvl_q), .div_q(div_q), .div_pend(div_pend), .cnt(cnt)
);

// File: tb/sd_clk_ctrl_bench.sv
`timescale 1ns/1ps
module sd_clk_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd1;
  logic [15:0] rd_data;
  logic        card_clk, op_start, soft_rst;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_clk_ctrl u_sd_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .card_clk(card_clk),
    .op_start(op_start), .soft_rst(soft_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_want, m_run, m_div, m_pend, m_cnt, m_lvl, m_busy, m_op, m_srst;

  always @(posedge clk) begin
    int n_want, n_run, n_div, n_pend, n_cnt, n_lvl, n_busy, n_op, n_srst;
    bit w; int a; int d;
    if (!rst_n) begin
      m_want = 0; m_run = 0; m_div = 0; m_pend = 0; m_cnt = 0;
      m_lvl = 0; m_busy = 0; m_op = 0; m_srst = 0;
    end else begin
      w = wr_en; a = wr_addr; d = wr_data;
      n_op = 0; n_srst = 0; n_want = m_want; n_pend = m_pend;
      n_busy = (m_busy > 0) ? m_busy - 1 : 0;
      if (w && m_busy == 0) begin
        if (a == 0) begin
          if (d[3]) begin
            n_srst = 1; n_busy = 8; n_want = 0; n_pend = 0;
          end else begin
            if (d[1]) n_want = 1;
            if (d[0]) n_want = 0;
            n_op = d[2];
          end
        end
        if (a == 2) n_pend = d & 7;
      end
      if (m_cnt == (1 << m_div) - 1) begin n_cnt = 0; n_div = m_pend; end
      else begin n_cnt = m_cnt + 1; n_div = m_div; end
      n_lvl = (n_div == 0) ? 0 : ((n_cnt >> (n_div - 1)) & 1);
      n_run = m_run;
      if (m_want != m_run && n_lvl == 0) n_run = m_want;
      m_want = n_want; m_run = n_run; m_div = n_div; m_pend = n_pend; m_cnt = n_cnt;
      m_lvl = n_lvl; m_busy = n_busy; m_op = n_op; m_srst = n_srst;
      #2;
      chk(op_start == m_op, "R4 op_start", op_start, m_op);
      chk(soft_rst == m_srst, "R5 soft_rst", soft_rst, m_srst);
      if (rd_addr == 2'd1) begin
        chk(rd_data[15] == (m_busy != 0), "R5 busy bit", rd_data[15], m_busy != 0);
        chk(rd_data[8] == m_run, "R7 running bit", rd_data[8], m_run);
      end else if (rd_addr == 2'd2) begin
        chk(rd_data == m_pend, "R1 divide readback", rd_data, m_pend);
      end else if (rd_addr == 2'd0) begin
        chk(rd_data == 0, "R3 control reads zero", rd_data, 0);
      end
      #6;
      chk(card_clk == (m_run != 0 && m_div != 0 && m_lvl != 0), "R8 R9 card_clk low phase",
          card_clk, (m_run != 0 && m_div != 0 && m_lvl != 0));
    end
  end

  // pulse width and edge monitors
  int edges = 0;
  realtime t_rise = 0;
  always @(posedge card_clk) begin edges++; t_rise = $realtime; end
  always @(negedge card_clk) if (rst_n)
    chk(($realtime - t_rise) > 4.9, "R8 high pulse width", int'($realtime - t_rise), 5);

  int busy_cycles = 0, op_pulses = 0, srst_pulses = 0;
  always @(posedge clk) begin
    #3;
    if (rst_n && rd_addr == 2'd1 && rd_data[15]) busy_cycles++;
    if (op_start) op_pulses++;
    if (soft_rst) srst_pulses++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  task automatic measure(input int n, input string req);
    int exp;
    edges = 0;
    cyc(1024);
    exp = 1024 >> n;
    chk(edges >= exp - 1 && edges <= exp + 1, req, edges, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int waited;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    // R10 reset state
    chk(rd_data == 0, "R10 status after reset", rd_data, 0);
    chk(card_clk == 0 && op_start == 0 && soft_rst == 0, "R10 outputs after reset",
        {card_clk, op_start, soft_rst}, 0);
    rd_addr = 2'd2; cyc(1);
    chk(rd_data == 0, "R10 divide after reset", rd_data, 0);
    rd_addr = 2'd1;

    // R1 n = 0
    wr(2'd0, 16'h0002);
    cyc(10);
    measure(0, "R1 edges n=0");

    // R1 R9 change divide while running
    wr(2'd2, 16'd3);
    rd_addr = 2'd2; cyc(2); rd_addr = 2'd1;
    cyc(40);
    measure(3, "R1 R9 edges n=3");

    // R3 R7 stop and poll
    wr(2'd0, 16'h0001);
    waited = 0;
    while (rd_data[8] && waited < 100) begin cyc(1); waited++; end
    chk(waited <= 8, "R7 stop seen within one period", waited, 8);
    measure(10, "R3 no edges after stop");

    // R4 start with operation in one write
    op_pulses = 0;
    wr(2'd0, 16'h0006);
    cyc(20);
    chk(op_pulses == 1, "R4 single op pulse", op_pulses, 1);
    chk(rd_data[8] == 1, "R3 running after start", rd_data[8], 1);

    // R2 slowest ratio
    wr(2'd2, 16'd7);
    cyc(300);
    measure(7, "R2 edges n=7");

    // R3 start and stop together: stop wins
    wr(2'd0, 16'h0003);
    cyc(200);
    chk(rd_data[8] == 0, "R3 stop wins", rd_data[8], 0);
    rd_addr = 2'd0; cyc(2);
    chk(rd_data == 0, "R3 control readback", rd_data, 0);
    rd_addr = 2'd1;

    // R5 R6 soft reset with writes during busy
    wr(2'd0, 16'h0002);
    cyc(200);
    busy_cycles = 0; srst_pulses = 0;
    wr(2'd0, 16'h0008);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0002);
    cyc(20);
    chk(busy_cycles == 8, "R5 busy length", busy_cycles, 8);
    chk(srst_pulses == 1, "R5 reset pulse count", srst_pulses, 1);
    rd_addr = 2'd2; cyc(1);
    chk(rd_data == 0, "R6 divide cleared", rd_data, 0);
    rd_addr = 2'd1;
    cyc(200);
    chk(rd_data[8] == 0, "R6 clock stopped by reset", rd_data[8], 0);
    measure(10, "R6 no edges after reset");

    // R6 divider back at 0 after restart, then R1 n = 1
    wr(2'd0, 16'h0002);
    cyc(10);
    measure(0, "R6 R1 edges after reset n=0");
    wr(2'd2, 16'd1);
    cyc(10);
    measure(1, "R1 edges n=1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule